// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a 16-bit register bus. A 15-bit down-counter moves one step on each cycle where the slow tick input is high. The tick is meant to run at 100 Hz, so one count is 10 ms and the longest timeout is about 327 s. Software can change the counter's state only by writing fixed 16-bit key values. These keys reload the counter, disable it (two keys in a fixed order), re-enable it and clear the status. A write that carries any other value leaves that state unchanged.

When the count passes one eighth of the programmed timeout, the block raises an early-warning event. A mask bit gates this event onto the interrupt output. When the count reaches zero, the block emits a one-cycle reset-request pulse, stops counting and sets a sticky timed-out status. Only power-on reset or the clear key removes that status. A debug-mode input holds the counter unless software has allowed it to run during debug.

Reads take one clock: the address is sampled with the read strobe, and the data is valid in the following cycle. Register offsets are byte addresses on a 4-byte stride.

Top module: `keyed_wdog`

## Requirements
- R1: Writing 0xFEED to offset 0x00 loads the counter from the timeout register in the next cycle. A write of any other value to 0x00 leaves the count unchanged.
- R2: Offset 0x04 holds the 15-bit timeout in bits 14:0 and reads back as written. While the counter runs, each cycle with `tick_en` high lowers a nonzero count by exactly one.
- R3: The counter is disabled only by writing 0xCAFE to offset 0x0C after 0x2BAD was written to offset 0x08. Other registers may be written in between. Any write to 0x0C uses up the arming, and so does a non-key write to 0x08. A 0xCAFE write with no arming has no effect.
- R4: Offset 0x0C reads 0xDABE while the counter is disabled and 0x0000 while it is enabled.
- R5: Writing 0xACED to offset 0x1C re-enables a disabled counter. The count is unchanged, so a count of zero stays idle until a feed reloads it.
- R6: A tick that lowers the count from 1 to 0 makes `rst_req_o` high for exactly the next cycle and disables the counter. A count of zero never produces a further pulse.
- R7: Offset 0x10 reads 0xCFE8 after an expiry and 0x0000 otherwise. Only power-on reset or a write of 0xE8B4 to 0x10 clears it. If an expiry happens in the same cycle as the clear, the status stays set.
- R8: Offset 0x14 returns the count in bits 14:0. Bit 15 reads 1 when `tick_en` was high in the read cycle, which means the value is changing.
- R9: The early-warning event (bit 0 of offset 0x20) is set when a tick lowers the count to the timeout shifted right by three bits.
- R10: Writing 1 to bit 0 of 0x20 clears the event. Writing 1 to bit 0 of 0x28 sets it, and a set beats a clear in the same cycle. Bit 0 of 0x24 is the mask, and `irq_o` is high while both the event and the mask are set.
- R11: While `dbg_mode_i` is high, the counter holds unless bit 0 of offset 0x18 is 1. Offset 0x18 reads `dbg_mode_i` in bit 1 and the stored run bit in bit 0.
- R12: After power-on reset the counter is enabled with count and timeout at 0x7FFF. The status is normal, the event, mask and debug-run bit are clear, and both outputs are low.
- R13: Reads of unmapped offsets, and of the write-only offsets 0x00, 0x08, 0x1C and 0x28, return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick_en | input | 1 | Slow count enable (one pulse per 10 ms) |
| dbg_mode_i | input | 1 | Debug mode active |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bound checker watches the following on every cycle:
- the reset pulse is a single cycle long, and on expiry the counter is zero and disabled;
- the status stays set across every cycle that has no clear key;
- a feed key loads the timeout;
- the count never moves by more than one step;
- the count holds while counting is not permitted;
- an unarmed second disable key leaves the counter enabled.

Some behaviour only the bench scenarios can show, because it spans a whole sequence against the bench's own register model:
- the exact readback codes;
- the timing of the one-eighth warning;
- the acknowledge and force priority;
- resuming followed by a feed;
- the debug-mode gating.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W = 16;
    localparam int REG_N  = 11;

    // register slot numbers; byte offset = slot * 4
    localparam int IX_FEED  = 0;
    localparam int IX_TOUT  = 1;
    localparam int IX_DIS1  = 2;
    localparam int IX_DIS2  = 3;
    localparam int IX_STAT  = 4;
    localparam int IX_CNT   = 5;
    localparam int IX_DBG   = 6;
    localparam int IX_RESUM = 7;
    localparam int IX_EVT   = 8;
    localparam int IX_MASK  = 9;
    localparam int IX_FORCE = 10;

    localparam logic [DATA_W-1:0] KEY_FEED   = 16'hFEED;
    localparam logic [DATA_W-1:0] KEY_ARM    = 16'h2BAD;
    localparam logic [DATA_W-1:0] KEY_KILL   = 16'hCAFE;
    localparam logic [DATA_W-1:0] KEY_RESUME = 16'hACED;
    localparam logic [DATA_W-1:0] KEY_CLEAR  = 16'hE8B4;
    localparam logic [DATA_W-1:0] CODE_OFF   = 16'hDABE;
    localparam logic [DATA_W-1:0] CODE_BITE  = 16'hCFE8;
endpackage

// File: rtl/wdg_decode.sv
module wdg_decode
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic [REG_N-1:0]  hit,
    output logic [REG_N-1:0]  wr_sel
);
    for (genvar g = 0; g < REG_N; g++) begin : g_slot
        assign hit[g]    = (addr == ADDR_W'(g * 4));
        assign wr_sel[g] = wr_en & hit[g];
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W      = 15,
    parameter int WARN_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] tout_i,
    output logic [CNT_W-1:0] count_o,
    output logic             warn_o,
    output logic             fire_o,
    output logic             pulse_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] dec;
    logic             adv;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        dec        = st_q.cnt - CNT_W'(1);
        adv        = !load_i && tick_en && run_i && (st_q.cnt != '0);
        warn_o     = 1'b0;
        fire_o     = 1'b0;
        if (load_i) begin
            st_d.cnt = tout_i;
        end else if (adv) begin
            st_d.cnt   = dec;
            warn_o     = (dec == (tout_i >> WARN_SHIFT));
            fire_o     = (st_q.cnt == CNT_W'(1));
            st_d.pulse = fire_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
    import wdg_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_N-1:0]  hit,
    input  logic [REG_N-1:0]  wr_sel,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_en,
    input  logic              dbg_mode_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              warn_i,
    input  logic              fire_i,
    output logic              load_o,
    output logic              run_o,
    output logic [CNT_W-1:0]  tout_o,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              en_o,
    output logic              arm_o,
    output logic              bite_o
);
    typedef struct packed {
        logic              en;
        logic              arm;
        logic              bite;
        logic              evt;
        logic              mask;
        logic              dbgrun;
        logic [CNT_W-1:0]  tout;
        logic [DATA_W-1:0] rdata;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        load_o = wr_sel[IX_FEED] && (wdata == KEY_FEED);

        if (wr_sel[IX_TOUT])  st_d.tout   = wdata[CNT_W-1:0];
        if (wr_sel[IX_DBG])   st_d.dbgrun = wdata[0];
        if (wr_sel[IX_MASK])  st_d.mask   = wdata[0];
        if (wr_sel[IX_DIS1])  st_d.arm    = (wdata == KEY_ARM);
        if (wr_sel[IX_DIS2]) begin
            st_d.arm = 1'b0;
            if (st_q.arm && wdata == KEY_KILL) st_d.en = 1'b0;
        end
        if (wr_sel[IX_RESUM] && wdata == KEY_RESUME) st_d.en   = 1'b1;
        if (wr_sel[IX_STAT] && wdata == KEY_CLEAR)   st_d.bite = 1'b0;
        if (wr_sel[IX_EVT] && wdata[0])              st_d.evt  = 1'b0;
        if ((wr_sel[IX_FORCE] && wdata[0]) || warn_i) st_d.evt = 1'b1;
        if (fire_i) begin
            st_d.en   = 1'b0;
            st_d.bite = 1'b1;
        end

        st_d.rdata = '0;
        if (rd_en) begin
            if (hit[IX_TOUT]) st_d.rdata = DATA_W'(st_q.tout);
            if (hit[IX_DIS2]) st_d.rdata = st_q.en ? '0 : CODE_OFF;
            if (hit[IX_STAT]) st_d.rdata = st_q.bite ? CODE_BITE : '0;
            if (hit[IX_CNT]) begin
                st_d.rdata             = DATA_W'(count_i);
                st_d.rdata[DATA_W-1]   = tick_en;
            end
            if (hit[IX_DBG])  st_d.rdata = {{(DATA_W-2){1'b0}}, dbg_mode_i, st_q.dbgrun};
            if (hit[IX_EVT])  st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.evt};
            if (hit[IX_MASK]) st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.mask};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en     <= 1'b1;
            st_q.arm    <= 1'b0;
            st_q.bite   <= 1'b0;
            st_q.evt    <= 1'b0;
            st_q.mask   <= 1'b0;
            st_q.dbgrun <= 1'b0;
            st_q.tout   <= '1;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = st_q.en && (!dbg_mode_i || st_q.dbgrun);
    assign tout_o = st_q.tout;
    assign rdata  = st_q.rdata;
    assign irq_o  = st_q.evt && st_q.mask;
    assign en_o   = st_q.en;
    assign arm_o  = st_q.arm;
    assign bite_o = st_q.bite;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int CNT_W      = 15,
    parameter int WARN_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              dbg_mode_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic [REG_N-1:0] hit, wr_sel;
    logic [CNT_W-1:0] count, tout;
    logic             load, run, warn, fire, en, arm, bite;

    wdg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .wr_en(wr_en), .hit(hit), .wr_sel(wr_sel)
    );

    wdg_counter #(.CNT_W(CNT_W), .WARN_SHIFT(WARN_SHIFT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_i(run),
        .load_i(load), .tout_i(tout), .count_o(count), .warn_o(warn),
        .fire_o(fire), .pulse_o(rst_req_o)
    );

    wdg_ctrl #(.CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wr_sel(wr_sel), .rd_en(rd_en),
        .wdata(wdata), .tick_en(tick_en), .dbg_mode_i(dbg_mode_i),
        .count_i(count), .warn_i(warn), .fire_i(fire), .load_o(load),
        .run_o(run), .tout_o(tout), .rdata(rdata), .irq_o(irq_o),
        .en_o(en), .arm_o(arm), .bite_o(bite)
    );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rst_req_o,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  tout,
    input logic              run,
    input logic              en,
    input logic              arm,
    input logic              bite
);
    logic feed_w;
    assign feed_w = wr_en && addr == ADDR_W'(IX_FEED * 4) && wdata == KEY_FEED;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R6
    AST_EXPIRE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (!en && count == '0 && bite)); // R6
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bite && !(wr_en && addr == ADDR_W'(IX_STAT * 4) && wdata == KEY_CLEAR)) |=> bite); // R7
    AST_FEED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        feed_w |=> count == $past(tout)); // R1
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !feed_w |=> (count == $past(count) || count == $past(count) - CNT_W'(1))); // R2
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !feed_w) |=> $stable(count)); // R11
    AST_LONE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IX_DIS2 * 4) && en && !arm) |=> (en || rst_req_o)); // R3
endmodule

bind keyed_wdog wdg_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rst_req_o(rst_req_o), .count(count), .tout(tout), .run(run),
    .en(en), .arm(arm), .bite(bite)
);

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, dbg = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_o, rst_req_o;

    int n_chk = 0, n_err = 0;

    // bench register model
    logic        m_en, m_arm, m_st, m_ev, m_mk, m_dr;
    logic [14:0] m_to, m_cn;

    always #5 clk = ~clk;

    keyed_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_mode_i(dbg),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h04: return "R2";  6'h0C: return "R4";  6'h10: return "R7";
            6'h14: return "R8";  6'h18: return "R11"; 6'h20: return "R9";
            6'h24: return "R10"; default: return "R13";
        endcase
    endfunction

    function automatic logic [15:0] exp_read(input logic [5:0] a, input logic t);
        case (a)
            6'h04: return {1'b0, m_to};
            6'h0C: return m_en ? 16'h0000 : 16'hDABE;
            6'h10: return m_st ? 16'hCFE8 : 16'h0000;
            6'h14: return {t, m_cn};
            6'h18: return {14'd0, dbg, m_dr};
            6'h20: return {15'd0, m_ev};
            6'h24: return {15'd0, m_mk};
            default: return 16'h0000;
        endcase
    endfunction

    // one bus cycle; called just after a rising edge
    task automatic step(input logic w, input logic r, input logic [5:0] a,
                        input logic [15:0] d, input logic t, input string req);
        logic        load, run, adv, fire, warn;
        logic [14:0] dec;
        logic [15:0] xr;
        wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = t;
        load = w && a == 6'h00 && d == 16'hFEED;
        run  = m_en && (!dbg || m_dr);
        dec  = m_cn - 15'd1;
        adv  = !load && t && run && m_cn != 15'd0;
        fire = adv && m_cn == 15'd1;
        warn = adv && dec == (m_to >> 3);
        xr   = exp_read(a, t);
        @(posedge clk);
        #1;
        if (load) m_cn = m_to; else if (adv) m_cn = dec;
        if (w) begin
            case (a)
                6'h04: m_to = d[14:0];
                6'h08: m_arm = (d == 16'h2BAD);
                6'h0C: begin if (m_arm && d == 16'hCAFE) m_en = 1'b0; m_arm = 1'b0; end
                6'h10: if (d == 16'hE8B4) m_st = 1'b0;
                6'h18: m_dr = d[0];
                6'h1C: if (d == 16'hACED) m_en = 1'b1;
                6'h20: if (d[0]) m_ev = 1'b0;
                6'h24: m_mk = d[0];
                default: ;
            endcase
        end
        if ((w && a == 6'h28 && d[0]) || warn) m_ev = 1'b1;
        if (fire) begin m_en = 1'b0; m_st = 1'b1; end
        chk("R6 reset request", {15'd0, rst_req_o}, {15'd0, fire});
        chk("R10 interrupt", {15'd0, irq_o}, {15'd0, m_ev && m_mk});
        if (r) chk(req == "" ? tag_of(a) : req, rdata, xr);
        wr_en = 1'b0; rd_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, "");
    endtask
    task automatic rd(input logic [5:0] a, input string req);
        step(1'b0, 1'b1, a, 16'h0, 1'b0, req);
    endtask
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 6'h3F, 16'h0, 1'b1, "");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        m_en = 1; m_arm = 0; m_st = 0; m_ev = 0; m_mk = 0; m_dr = 0;
        m_to = 15'h7FFF; m_cn = 15'h7FFF;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset request low", {15'd0, rst_req_o}, 16'd0);
        chk("R12 interrupt low", {15'd0, irq_o}, 16'd0);
        rst_n = 1'b1;
        // R12 reset state
        rd(6'h0C, "R12 enabled");
        rd(6'h10, "R12 status");
        rd(6'h04, "R12 timeout");
        rd(6'h14, "R12 count");
        rd(6'h18, "R12 debug");
        // R2 / R1 timeout and feed keys
        wr(6'h04, 16'd16);
        rd(6'h04, "R2 timeout");
        wr(6'h00, 16'h1234);
        rd(6'h14, "R1 bad feed ignored");
        wr(6'h00, 16'hFEED);
        rd(6'h14, "R1 feed reload");
        tick(3);
        rd(6'h14, "R2 count after ticks");
        step(1'b0, 1'b1, 6'h14, 16'h0, 1'b1, "R8 changing flag");
        // R9 / R10 warning and irq
        wr(6'h24, 16'h1);
        tick(10);
        rd(6'h20, "R9 warning set");
        wr(6'h20, 16'h1);
        rd(6'h20, "R10 acknowledged");
        wr(6'h28, 16'h1);
        rd(6'h20, "R10 forced");
        wr(6'h20, 16'h1);
        // R6 / R7 expiry
        tick(4);
        rd(6'h0C, "R6 disabled after expiry");
        rd(6'h10, "R7 timed out");
        wr(6'h10, 16'h1111);
        rd(6'h10, "R7 wrong key keeps status");
        tick(3);
        // R5 resume then feed
        wr(6'h1C, 16'hACED);
        rd(6'h0C, "R5 resumed");
        tick(2);
        rd(6'h14, "R5 zero stays idle");
        wr(6'h00, 16'hFEED);
        tick(1);
        rd(6'h14, "R5 counting again");
        // R3 ordered disable
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, "R3 lone second key");
        wr(6'h08, 16'h2BAD);
        wr(6'h24, 16'h0);
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, "R3 disabled");
        tick(2);
        rd(6'h14, "R3 count frozen");
        wr(6'h10, 16'hE8B4);
        rd(6'h10, "R7 cleared");
        // R11 debug gating
        wr(6'h1C, 16'hACED);
        wr(6'h00, 16'hFEED);
        dbg = 1'b1;
        tick(3);
        rd(6'h14, "R11 held in debug");
        rd(6'h18, "R11 debug flag");
        wr(6'h18, 16'h1);
        tick(2);
        rd(6'h14, "R11 runs when allowed");
        rd(6'h18, "R11 run bit");
        dbg = 1'b0;
        rd(6'h2C, "R13 unmapped");
        rd(6'h1C, "R13 write-only");
        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            int unsigned op;
            logic [5:0]  a;
            logic [15:0] d;
            op = $urandom % 16;
            a  = 6'(($urandom % 12) * 4);
            case ($urandom % 8)
                0: d = 16'hFEED;  1: d = 16'h2BAD;  2: d = 16'hCAFE;
                3: d = 16'hACED;  4: d = 16'hE8B4;  5: d = 16'($urandom % 64);
                default: d = 16'($urandom % 2);
            endcase
            if (a == 6'h04) d = 16'($urandom % 48);
            if ($urandom % 64 == 0) dbg = ~dbg;
            if (op < 5)       step(1'b1, 1'b0, a, d, 1'($urandom % 2), "");
            else if (op < 10) step(1'b0, 1'b1, a, 16'h0, 1'($urandom % 2), "");
            else              step(1'b0, 1'b0, 6'h3F, 16'h0, 1'b1, "");
        end
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule